// File: doc/BRIEF.md
# Inclusive Last-Level Cache Presence Directory

This block is the tag-and-directory controller of a shared, inclusive last-level cache serving several cores. Each directory entry holds a valid flag, a dirty flag, a tag and one presence bit per core. The block takes read, ownership (read-for-ownership) and dirty write-back requests from the cores, one at a time. For each request it decides whether the last-level copy can answer at once or whether the cores whose presence bits are set must be probed first. It then drives the probe, collects the answers, and rewrites the presence bits and flags. On a miss it back-invalidates the direct-mapped victim, writes the victim to memory if it is dirty, and fetches the new line over a simple memory request/response port.

Presence bits are conservative. A core may drop a clean line without telling the directory, so a clear bit proves absence but a set bit is only a hint. A line held by one core can therefore hold newer data there and must be probed before another core may read it. When two or more bits are set, the line is shared and clean, so the last-level copy is served directly.

The controller is a Moore state machine with states IDLE, LOOKUP, SNOOP, EVICT, EVICT_WB, FILL and DONE. IDLE goes to LOOKUP when it accepts a request. LOOKUP goes to DONE for a write-back or a hit with no probe, to SNOOP for a hit that needs a probe, and on a miss to EVICT (the victim has presence bits), to EVICT_WB (the victim is dirty with no bits set) or to FILL. SNOOP goes to DONE on the probe answer. EVICT goes to EVICT_WB if the victim ends up dirty, and to FILL otherwise. EVICT_WB goes to FILL on the memory answer. FILL goes to DONE on the memory answer. DONE always returns to IDLE.

Top module: `llc_snoop_filter`

## Requirements
- R1: A probe or back-invalidate is sent only to cores whose presence bit is set for that line. The probe mask is held stable until `snp_ack_valid`.
- R2: A read hit on a line whose only set presence bit belongs to another core sends a read probe (`snp_inv`=0) to that single core. The answer has `rsp_src`=1 (core) if that core reports dirty, and `rsp_src`=0 (cache) otherwise.
- R3: A read hit on a line with two or more presence bits set, or with no bit set for any other core, is answered with `rsp_src`=0 and no probe. The requester's bit is then set.
- R4: An ownership request (`req_op`=1) that hits a line with other presence bits set sends an invalidating probe (`snp_inv`=1) to all of them. Afterwards only the requester's bit remains.
- R5: A probed core that answers with `snp_ack_hit`=0 has its presence bit cleared. A read-probed core that answers with a hit keeps its bit.
- R6: A write-back (`req_op`=2) clears the writer's presence bit and marks the line dirty. It is answered with `rsp_src`=0 and causes no probe and no memory access.
- R7: A miss fetches the line with a memory read (`mem_req_we`=0) at the request address. The answer has `rsp_src`=2 (memory), and the new entry holds only the requester's bit.
- R8: On a miss whose victim has presence bits set, an invalidating probe goes to exactly those cores. If the victim was dirty, or a core reports dirty, a memory write (`mem_req_we`=1) to the victim address precedes the fill.
- R9: Only one transaction is in flight. `req_ready` is low from the cycle after acceptance through the single-cycle `rsp_valid` pulse. The address is {tag, index}, with the index in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle (idle) |
| req_core | input | log2(N_CORES) | Requesting core |
| req_op | input | 2 | 0 read, 1 ownership, 2 write-back |
| req_addr | input | ADDR_W | Line address {tag, index} |
| snp_valid | output | 1 | Probe outstanding |
| snp_mask | output | N_CORES | Cores probed |
| snp_inv | output | 1 | 1 invalidate, 0 read probe |
| snp_ack_valid | input | 1 | Probe answers present |
| snp_ack_hit | input | N_CORES | Core still holds the line |
| snp_ack_dirty | input | N_CORES | Core held it modified |
| mem_req_valid | output | 1 | Memory access outstanding |
| mem_req_we | output | 1 | 1 victim write, 0 fill read |
| mem_req_addr | output | ADDR_W | Memory line address |
| mem_rsp_valid | input | 1 | Memory access complete |
| rsp_valid | output | 1 | Request answered (one cycle) |
| rsp_core | output | log2(N_CORES) | Core being answered |
| rsp_src | output | 2 | 0 cache, 1 core, 2 memory |

## Verification
A corrupted presence vector does not show up when it happens. It shows up on the next request to that line, as a probe mask with an extra or missing core, as a probe where none should be, or as a direct answer where a probe was due. A wrong dirty flag stays hidden until the line is evicted, when a memory write appears or goes missing. The bench therefore replays every line through read, shared read, ownership, write-back, re-read and conflict eviction, with each probe-answer pattern. Every probe, memory access and answer is compared against an arithmetic model of the directory, so an error surfaces within one or two requests.

// File: rtl/sf_pkg.sv
package sf_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_RFO   = 2'd1,
        OP_WBACK = 2'd2
    } req_op_e;

    typedef enum logic [1:0] {
        SRC_LLC  = 2'd0,
        SRC_CORE = 2'd1,
        SRC_MEM  = 2'd2
    } rsp_src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SNOOP,
        ST_EVICT,
        ST_EVICT_WB,
        ST_FILL,
        ST_DONE
    } sf_state_e;
endpackage

// File: rtl/sf_dir_array.sv
module sf_dir_array #(
    parameter int SETS  = 8,
    parameter int TAG_W = 5,
    parameter int NC    = 4,
    localparam int IW   = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic [NC-1:0]    rd_pres,
    input  logic             we,
    input  logic [IW-1:0]    wr_idx,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [NC-1:0]    wr_pres
);
    logic             valid_q [SETS];
    logic             dirty_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS];
    logic [NC-1:0]    pres_q  [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
                tag_q[i]   <= '0;
                pres_q[i]  <= '0;
            end
        end else if (we) begin
            valid_q[wr_idx] <= wr_valid;
            dirty_q[wr_idx] <= wr_dirty;
            tag_q[wr_idx]   <= wr_tag;
            pres_q[wr_idx]  <= wr_pres;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_pres  = pres_q[rd_idx];
endmodule

// File: rtl/sf_snoop_decide.sv
module sf_snoop_decide #(
    parameter int NC = 4
) (
    input  logic          is_rfo,
    input  logic [NC-1:0] req_bit,
    input  logic [NC-1:0] pres,
    output logic          need_snoop,
    output logic          snoop_inv,
    output logic [NC-1:0] snoop_mask
);
    logic [NC-1:0] others;
    logic          multi;

    always_comb begin
        others     = pres & ~req_bit;
        multi      = (pres & (pres - NC'(1))) != '0;
        snoop_mask = others;
        snoop_inv  = is_rfo;
        if (is_rfo) need_snoop = (others != '0);
        else        need_snoop = !multi && (others != '0);
    end
endmodule

// File: rtl/llc_snoop_filter.sv
module llc_snoop_filter
    import sf_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int SETS    = 8,
    parameter int ADDR_W  = 8,
    localparam int CW     = $clog2(N_CORES),
    localparam int IW     = $clog2(SETS),
    localparam int TW     = ADDR_W - IW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [CW-1:0]      req_core,
    input  logic [1:0]         req_op,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               snp_valid,
    output logic [N_CORES-1:0] snp_mask,
    output logic               snp_inv,
    input  logic               snp_ack_valid,
    input  logic [N_CORES-1:0] snp_ack_hit,
    input  logic [N_CORES-1:0] snp_ack_dirty,
    output logic               mem_req_valid,
    output logic               mem_req_we,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    output logic               rsp_valid,
    output logic [CW-1:0]      rsp_core,
    output logic [1:0]         rsp_src
);
    sf_state_e          state_q, state_d;
    logic [CW-1:0]      core_q, core_d;
    req_op_e            op_q, op_d;
    logic [ADDR_W-1:0]  addr_q, addr_d;
    logic [N_CORES-1:0] tgt_q, tgt_d;
    logic               inv_q, inv_d;
    logic               vdirty_q, vdirty_d;
    logic [TW-1:0]      vtag_q, vtag_d;
    rsp_src_e           src_q, src_d;

    logic               rd_valid, rd_dirty;
    logic [TW-1:0]      rd_tag;
    logic [N_CORES-1:0] rd_pres;
    logic               dir_we, wr_valid, wr_dirty;
    logic [N_CORES-1:0] wr_pres;
    logic [TW-1:0]      wr_tag;

    logic [N_CORES-1:0] req_bit, dec_mask, ack_hit, ack_dirty;
    logic               dec_need, dec_inv, hit;
    logic [IW-1:0]      cur_idx;
    logic [TW-1:0]      cur_tag;

    assign cur_idx   = addr_q[IW-1:0];
    assign cur_tag   = addr_q[ADDR_W-1:IW];
    assign req_bit   = N_CORES'(1) << core_q;
    assign hit       = rd_valid && (rd_tag == cur_tag);
    assign ack_hit   = snp_ack_hit & tgt_q;
    assign ack_dirty = snp_ack_dirty & tgt_q;

    sf_dir_array #(.SETS(SETS), .TAG_W(TW), .NC(N_CORES)) dir_i (
        .clk(clk), .rst_n(rst_n), .rd_idx(cur_idx),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_pres(rd_pres),
        .we(dir_we), .wr_idx(cur_idx), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
        .wr_tag(wr_tag), .wr_pres(wr_pres)
    );

    sf_snoop_decide #(.NC(N_CORES)) dec_i (
        .is_rfo(op_q == OP_RFO), .req_bit(req_bit), .pres(rd_pres),
        .need_snoop(dec_need), .snoop_inv(dec_inv), .snoop_mask(dec_mask)
    );

    // next state, datapath and directory update
    always_comb begin
        state_d  = state_q;
        core_d   = core_q;
        op_d     = op_q;
        addr_d   = addr_q;
        tgt_d    = tgt_q;
        inv_d    = inv_q;
        vdirty_d = vdirty_q;
        vtag_d   = vtag_q;
        src_d    = src_q;
        dir_we   = 1'b0;
        wr_valid = rd_valid;
        wr_dirty = rd_dirty;
        wr_tag   = rd_tag;
        wr_pres  = rd_pres;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                core_d  = req_core;
                op_d    = req_op_e'(req_op);
                addr_d  = req_addr;
                state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (op_q == OP_WBACK) begin
                    dir_we   = hit;
                    wr_pres  = rd_pres & ~req_bit;
                    wr_dirty = 1'b1;
                    src_d    = SRC_LLC;
                    state_d  = ST_DONE;
                end else if (hit) begin
                    if (dec_need) begin
                        tgt_d   = dec_mask;
                        inv_d   = dec_inv;
                        state_d = ST_SNOOP;
                    end else begin
                        dir_we  = 1'b1;
                        wr_pres = (op_q == OP_RFO) ? req_bit : (rd_pres | req_bit);
                        src_d   = SRC_LLC;
                        state_d = ST_DONE;
                    end
                end else begin
                    vtag_d   = rd_tag;
                    vdirty_d = rd_valid && rd_dirty;
                    tgt_d    = rd_pres;
                    inv_d    = 1'b1;
                    if (rd_valid && rd_pres != '0)  state_d = ST_EVICT;
                    else if (rd_valid && rd_dirty)  state_d = ST_EVICT_WB;
                    else                            state_d = ST_FILL;
                end
            end
            ST_SNOOP: if (snp_ack_valid) begin
                dir_we   = 1'b1;
                wr_pres  = inv_q ? req_bit : ((rd_pres & ~(tgt_q & ~ack_hit)) | req_bit);
                wr_dirty = rd_dirty | (ack_dirty != '0);
                src_d    = (ack_dirty != '0) ? SRC_CORE : SRC_LLC;
                state_d  = ST_DONE;
            end
            ST_EVICT: if (snp_ack_valid) begin
                vdirty_d = vdirty_q | (ack_dirty != '0);
                state_d  = (vdirty_q | (ack_dirty != '0)) ? ST_EVICT_WB : ST_FILL;
            end
            ST_EVICT_WB: if (mem_rsp_valid) state_d = ST_FILL;
            ST_FILL: if (mem_rsp_valid) begin
                dir_we   = 1'b1;
                wr_valid = 1'b1;
                wr_dirty = 1'b0;
                wr_tag   = cur_tag;
                wr_pres  = req_bit;
                src_d    = SRC_MEM;
                state_d  = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            core_q   <= '0;
            op_q     <= OP_READ;
            addr_q   <= '0;
            tgt_q    <= '0;
            inv_q    <= 1'b0;
            vdirty_q <= 1'b0;
            vtag_q   <= '0;
            src_q    <= SRC_LLC;
        end else begin
            state_q  <= state_d;
            core_q   <= core_d;
            op_q     <= op_d;
            addr_q   <= addr_d;
            tgt_q    <= tgt_d;
            inv_q    <= inv_d;
            vdirty_q <= vdirty_d;
            vtag_q   <= vtag_d;
            src_q    <= src_d;
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        snp_valid     = (state_q == ST_SNOOP) || (state_q == ST_EVICT);
        snp_mask      = tgt_q;
        snp_inv       = inv_q;
        mem_req_valid = (state_q == ST_EVICT_WB) || (state_q == ST_FILL);
        mem_req_we    = (state_q == ST_EVICT_WB);
        mem_req_addr  = (state_q == ST_EVICT_WB) ? {vtag_q, cur_idx} : addr_q;
        rsp_valid     = (state_q == ST_DONE);
        rsp_core      = core_q;
        rsp_src       = src_q;
    end

    p_snp_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> (snp_mask != '0));
    p_snp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_ack_valid) |=> (snp_valid && $stable(snp_mask) && $stable(snp_inv)));
    p_read_probe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_inv) |-> $onehot(snp_mask));
    p_no_self_probe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SNOOP) |-> ((snp_mask & req_bit) == '0));
    p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    p_rsp_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
endmodule

// File: tb/llc_snoop_filter_tb_top.sv
`timescale 1ns/1ps
module llc_snoop_filter_tb_top;
    localparam int NC = 4, SETS = 8, AW = 8, IW = 3, TW = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          req_valid = 0, req_ready;
    logic [1:0]    req_core = 0;
    logic [1:0]    req_op = 0;
    logic [AW-1:0] req_addr = 0;
    logic          snp_valid, snp_inv;
    logic [NC-1:0] snp_mask;
    logic          snp_ack_valid = 0;
    logic [NC-1:0] snp_ack_hit = 0, snp_ack_dirty = 0;
    logic          mem_req_valid, mem_req_we, mem_rsp_valid = 0;
    logic [AW-1:0] mem_req_addr;
    logic          rsp_valid;
    logic [1:0]    rsp_core, rsp_src;

    llc_snoop_filter #(.N_CORES(NC), .SETS(SETS), .ADDR_W(AW)) dut_i (.*);

    int vectors = 0, fails = 0, cycles = 0;

    // bench model of the directory
    logic          m_valid [SETS];
    logic          m_dirty [SETS];
    logic [TW-1:0] m_tag   [SETS];
    logic [NC-1:0] m_pres  [SETS];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            $display("FAIL R9 watchdog expired: actual %0d expected <190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic do_req(input int core, input int op, input logic [AW-1:0] addr,
                          input logic [NC-1:0] ahit, input logic [NC-1:0] adirty,
                          input string tag);
        int            idx = int'(addr[IW-1:0]);
        logic [TW-1:0] tg = addr[AW-1:IW];
        logic [NC-1:0] b = NC'(1) << core;
        int            kind [3];
        logic [NC-1:0] emask [3];
        logic          einv [3];
        logic [AW-1:0] eaddr [3];
        int            n = 0, k = 0;
        logic [1:0]    esrc = 2'd0;
        bit            done = 0, saw_ready = 0;
        logic [NC-1:0] h, d, oth;
        bit            hit = m_valid[idx] && m_tag[idx] == tg;
        // model: expected events and new directory state
        if (op == 2) begin
            if (hit) begin m_pres[idx] &= ~b; m_dirty[idx] = 1'b1; end
        end else if (hit) begin
            oth = m_pres[idx] & ~b;
            if ((op == 1 && oth != 0) || (op == 0 && $countones(m_pres[idx]) == 1 && oth != 0)) begin
                kind[n] = 0; emask[n] = oth; einv[n] = (op == 1); n++;
                h = ahit & oth; d = adirty & oth;
                if (op == 1) m_pres[idx] = b;
                else         m_pres[idx] = (m_pres[idx] & ~(oth & ~h)) | b;
                if (d != 0) begin m_dirty[idx] = 1'b1; esrc = 2'd1; end
            end else begin
                m_pres[idx] = (op == 1) ? b : (m_pres[idx] | b);
            end
        end else begin
            bit vd = m_valid[idx] && m_dirty[idx];
            if (m_valid[idx] && m_pres[idx] != 0) begin
                kind[n] = 0; emask[n] = m_pres[idx]; einv[n] = 1'b1; n++;
                if ((adirty & m_pres[idx]) != 0) vd = 1;
            end
            if (vd) begin kind[n] = 1; eaddr[n] = {m_tag[idx], addr[IW-1:0]}; n++; end
            kind[n] = 2; eaddr[n] = addr; n++;
            m_valid[idx] = 1'b1; m_dirty[idx] = 1'b0; m_tag[idx] = tg; m_pres[idx] = b;
            esrc = 2'd2;
        end
        // drive
        @(negedge clk);
        req_valid = 1; req_core = 2'(core); req_op = 2'(op); req_addr = addr;
        for (int cyc = 0; cyc < 64 && !done; cyc++) begin
            @(negedge clk);
            req_valid = 0; snp_ack_valid = 0; mem_rsp_valid = 0;
            if (req_ready) saw_ready = 1;
            if (rsp_valid) begin
                done = 1;
                chk(k == n, tag, "events before answer", k, n);
                chk(rsp_core == 2'(core), tag, "rsp_core", rsp_core, core);
                chk(rsp_src == esrc, tag, "rsp_src", rsp_src, esrc);
            end else if (snp_valid) begin
                // R1: the mask must equal exactly the modelled set bits
                chk(k < n && kind[k] == 0, tag, "unexpected probe", snp_mask, 0);
                if (k < n && kind[k] == 0) begin
                    chk(snp_mask == emask[k], tag, "snp_mask", snp_mask, emask[k]);
                    chk(snp_inv == einv[k], tag, "snp_inv", snp_inv, einv[k]);
                end
                snp_ack_valid = 1; snp_ack_hit = ahit; snp_ack_dirty = adirty;
                k++;
            end else if (mem_req_valid) begin
                chk(k < n && kind[k] != 0, tag, "unexpected memory access", mem_req_addr, 0);
                if (k < n && kind[k] != 0) begin
                    chk(mem_req_we == (kind[k] == 1), tag, "mem_req_we", mem_req_we, kind[k] == 1);
                    chk(mem_req_addr == eaddr[k], tag, "mem_req_addr", mem_req_addr, eaddr[k]);
                end
                mem_rsp_valid = 1;
                k++;
            end
        end
        chk(done, tag, "answer seen", done, 1);
        chk(!saw_ready, "R9", "req_ready while busy", saw_ready, 0);
    endtask

    initial begin
        for (int i = 0; i < SETS; i++) begin
            m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; m_pres[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !snp_valid && !mem_req_valid && !rsp_valid, "R9", "reset outputs",
            {req_ready, snp_valid, mem_req_valid, rsp_valid}, 4'b1000);
        for (int idx = 0; idx < SETS; idx++)
            for (int c = 0; c < NC; c++)
                for (int pat = 0; pat < 3; pat++) begin
                    logic [TW-1:0] ta = TW'(c * 6 + pat * 2);
                    logic [AW-1:0] aa = {ta, IW'(idx)};
                    logic [AW-1:0] ab = {ta + TW'(1), IW'(idx)};
                    logic [NC-1:0] hh = (pat >= 1) ? '1 : '0;
                    logic [NC-1:0] dd = (pat == 2) ? '1 : '0;
                    int cb = (c + 1) % NC, cd = (c + 2) % NC, ce = (c + 3) % NC;
                    do_req(c,  0, aa, '0, '0, "R7");
                    do_req(cb, 0, aa, hh, dd, "R2");
                    do_req(cd, 0, aa, hh, dd, "R3");
                    do_req(ce, 1, aa, hh, dd, (pat == 0) ? "R5" : "R4");
                    do_req(ce, 2, aa, '0, '0, "R6");
                    do_req(c,  0, aa, hh, '0, "R6");
                    do_req(cb, 0, ab, hh, dd, "R8");
                end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule